// File: doc/BRIEF.md
# Selectable-Mode Fixed-Point Rounder

This block narrows a signed two's-complement fixed-point sample. It removes some of the fractional bits, or all of them when the result must be an integer. A two-bit mode input, which may change on any cycle, picks how the removed part is resolved. The choices are plain truncation toward minus infinity, round-to-nearest with ties going up, round-to-nearest with ties going away from zero, and round-to-nearest with ties going to the even neighbour. In every rounding mode, a value that is not an exact tie goes to the nearer neighbour.

The block sits after a datapath that grows fractional precision, such as a filter or an iterative angle engine, and before a narrower consumer. Each sample is marked by a valid strobe. The result appears one clock later with its own valid strobe. When rounding up would carry past the most positive output code, the result is clamped to that code. The input width, the input fraction length and the output fraction length are parameters. The output width is derived from them.

Top module: `fxr_round_unit`

## Requirements
- R1: A synchronous active-high reset drives `out_valid` to 0 and `out_data` to all zeros by the first clock edge after reset is applied. Both stay there while reset is held, whatever the other inputs do.
- R2: `out_valid` is 1 in the cycle after a clock edge that sampled `in_valid` = 1, and 0 in the cycle after one that sampled `in_valid` = 0. The `out_data` shown with it belongs to that sampled input.
- R3: Mode 2'b00 (truncate) gives floor(x). Examples: 1.5 gives 1, -0.25 gives -1, -0.75 gives -1.
- R4: Mode 2'b01 (half-up) sends an exact tie to the upper neighbour. Examples: 0.5 gives 1, -0.5 gives 0, 1.5 gives 2.
- R5: Mode 2'b10 (half-away-from-zero) sends an exact tie away from zero. Examples: 0.5 gives 1, -0.5 gives -1, -1.5 gives -2.
- R6: Mode 2'b11 (half-even) sends an exact tie to the neighbour whose least significant bit is 0. Examples: 0.5 gives 0, 1.5 gives 2, -0.5 gives 0, -1.5 gives -2.
- R7: In modes 2'b01, 2'b10 and 2'b11, a value that is not an exact tie goes to the nearer of its two neighbours. Examples: 0.25 gives 0, -0.25 gives 0, -0.75 gives -1, 1.0 gives 1.
- R8: When a rounding mode would move the result above the largest positive output code, the output is that largest code (0 followed by all ones).
- R9: While `in_valid` is 0, `out_data` keeps its previous value.
- R10: A tie is exactly a set first removed bit with every lower removed bit clear. This holds even when only one bit is removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a sample on `in_data` |
| in_data | input | IN_W | Signed input with IN_FRAC fractional bits |
| in_mode | input | 2 | 00 truncate, 01 half-up, 10 half-away, 11 half-even |
| out_valid | output | 1 | Registered valid, one cycle after `in_valid` |
| out_data | output | IN_W-(IN_FRAC-OUT_FRAC) | Signed result with OUT_FRAC fractional bits |

## Verification
The hardest cases to reach are the ones where the retained part already sits at the most positive code and a tie or above-half fraction asks for an increment. Saturation and the tie rules then interact: in half-even mode a tie on an odd maximum code must clamp, not wrap. These cases, and the negative ties, are reached by sweeping every input code through all four modes. Idle cycles with changing data are placed between samples. A second instance removes a single bit, so it has no lower discarded bits, and takes the same sweep. That covers the degenerate tie test.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

  typedef enum logic [1:0] {
    RND_TRUNC     = 2'b00,
    RND_HALF_UP   = 2'b01,
    RND_HALF_AWAY = 2'b10,
    RND_HALF_EVEN = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic guard;   // first removed bit
    logic sticky;  // OR of every lower removed bit
  } rem_flags_t;

endpackage

// File: rtl/fxr_frac_split.sv
module fxr_frac_split
  import fxr_pkg::*;
#(
  parameter int IN_W = 10,
  parameter int DROP = 3
) (
  input  logic [IN_W-1:0]      din,
  output logic [IN_W-DROP-1:0] kept,
  output rem_flags_t           flags
);

  assign kept        = din[IN_W-1:DROP];
  assign flags.guard = din[DROP-1];

  generate
    if (DROP == 1) begin : g_single
      assign flags.sticky = 1'b0;
    end else begin : g_multi
      assign flags.sticky = |din[DROP-2:0];
    end
  endgenerate

endmodule

// File: rtl/fxr_inc_decide.sv
module fxr_inc_decide
  import fxr_pkg::*;
(
  input  rnd_mode_e  mode,
  input  logic       sign,
  input  logic       kept_lsb,
  input  rem_flags_t flags,
  output logic       inc
);

  logic tie;
  logic over_half;

  always_comb begin
    tie       = flags.guard & ~flags.sticky;
    over_half = flags.guard &  flags.sticky;
    unique case (mode)
      RND_TRUNC:     inc = 1'b0;
      RND_HALF_UP:   inc = flags.guard;
      RND_HALF_AWAY: inc = over_half | (tie & ~sign);
      RND_HALF_EVEN: inc = over_half | (tie & kept_lsb);
      default:       inc = 1'b0;
    endcase
  end

endmodule

// File: rtl/fxr_sat_inc.sv
module fxr_sat_inc #(
  parameter int OUT_W = 7
) (
  input  logic [OUT_W-1:0] kept,
  input  logic             inc,
  output logic [OUT_W-1:0] res
);

  localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};

  logic at_top;

  always_comb begin
    at_top = (kept == MAX_POS);
    if (inc && at_top) begin
      res = MAX_POS;
    end else begin
      res = kept + {{(OUT_W-1){1'b0}}, inc};
    end
  end

endmodule

// File: rtl/fxr_round_unit.sv
module fxr_round_unit
  import fxr_pkg::*;
#(
  parameter int IN_W     = 10,
  parameter int IN_FRAC  = 3,
  parameter int OUT_FRAC = 0,
  localparam int DROP    = IN_FRAC - OUT_FRAC,
  localparam int OUT_W   = IN_W - DROP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  logic [OUT_W-1:0] kept;
  rem_flags_t       flags;
  logic             inc;
  logic [OUT_W-1:0] rounded;

  fxr_frac_split #(.IN_W(IN_W), .DROP(DROP)) u_split (
    .din  (in_data),
    .kept (kept),
    .flags(flags)
  );

  fxr_inc_decide u_decide (
    .mode    (rnd_mode_e'(in_mode)),
    .sign    (in_data[IN_W-1]),
    .kept_lsb(kept[0]),
    .flags   (flags),
    .inc     (inc)
  );

  fxr_sat_inc #(.OUT_W(OUT_W)) u_sat (
    .kept(kept),
    .inc (inc),
    .res (rounded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= rounded;
      end
    end
  end

endmodule

// File: rtl/fxr_round_chk.sv
module fxr_round_chk #(
  parameter int IN_W = 10,
  parameter int DROP = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [IN_W-1:0]      in_data,
  input logic [1:0]           in_mode,
  input logic                 out_valid,
  input logic [IN_W-DROP-1:0] out_data
);

  localparam int OUT_W = IN_W - DROP;
  localparam logic [OUT_W-1:0] TOP_CODE = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [DROP-1:0]  HALF_PAT = DROP'(1) << (DROP - 1);

  logic [OUT_W-1:0] k_c;
  logic             tie_c;
  logic             top_c;

  assign k_c   = in_data[IN_W-1:DROP];
  assign tie_c = (in_data[DROP-1:0] == HALF_PAT);
  assign top_c = (k_c == TOP_CODE);

  // R2
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R3
  assert_trunc_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'b00) |=> out_data == $past(k_c));

  // R7: rounding moves up by at most one step
  assert_round_step_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode != 2'b00 && !top_c) |=>
      (out_data == $past(k_c)) || (out_data == $past(k_c) + 1'b1));

  // R8
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && top_c) |=> out_data == TOP_CODE);

  // R5: negative tie stays on the floor
  assert_away_neg_tie_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'b10 && tie_c && in_data[IN_W-1]) |=>
      out_data == $past(k_c));

  // R6 and R10: tie lands on an even code unless clamped
  assert_even_tie_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'b11 && tie_c && !top_c) |=> !out_data[0]);

endmodule

bind fxr_round_unit fxr_round_chk #(.IN_W(IN_W), .DROP(DROP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_data  (in_data),
  .in_mode  (in_mode),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/sim_fxr_round_unit.sv
module sim_fxr_round_unit;

  localparam int A_W = 10, A_F = 3;   // u0: drop 3 bits
  localparam int B_W = 6,  B_F = 1;   // u1: drop 1 bit (R10)
  localparam int A_OW = A_W - A_F;
  localparam int B_OW = B_W - B_F;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst;
  logic             in_valid;
  logic [1:0]       in_mode;
  logic [A_W-1:0]   a_in;
  logic [B_W-1:0]   b_in;
  logic             a_ov, b_ov;
  logic [A_OW-1:0]  a_out;
  logic [B_OW-1:0]  b_out;

  fxr_round_unit #(.IN_W(A_W), .IN_FRAC(A_F), .OUT_FRAC(0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(a_in),
    .in_mode(in_mode), .out_valid(a_ov), .out_data(a_out));

  fxr_round_unit #(.IN_W(B_W), .IN_FRAC(B_F), .OUT_FRAC(0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(b_in),
    .in_mode(in_mode), .out_valid(b_ov), .out_data(b_out));

  int checks = 0;
  int fails  = 0;

  // expected state per instance
  bit    ea_v, eb_v;
  int    ea_d, eb_d;
  string ea_t, eb_t, v_tag;

  function automatic int sx(int code, int w);
    return (code >= (1 << (w - 1))) ? code - (1 << w) : code;
  endfunction

  function automatic int ref_round(int x, int drop, int ow, int mode,
                                   output string tag);
    int fl, rem, half, r, mx;
    fl   = x >>> drop;
    rem  = x - fl * (1 << drop);
    half = 1 << (drop - 1);
    case (mode)
      0: r = fl;
      1: r = (rem >= half) ? fl + 1 : fl;
      2: r = (rem > half || (rem == half && x >= 0)) ? fl + 1 : fl;
      default: r = (rem > half || (rem == half && (fl % 2) != 0)) ? fl + 1 : fl;
    endcase
    mx = (1 << (ow - 1)) - 1;
    if (r > mx) begin
      r = mx; tag = "R8";
    end else if (mode == 0) tag = "R3";
    else if (rem == half) begin
      tag = (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R6";
      if (drop == 1) tag = {tag, "/R10"};
    end else tag = "R7";
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge: compare outputs, then drive next inputs
  task automatic step(bit v, int code, int mode);
    string ta, tb;
    chk(v_tag, int'(a_ov), int'(ea_v));
    chk(ea_t, sx(int'(a_out), A_OW), ea_d);
    chk(v_tag, int'(b_ov), int'(eb_v));
    chk(eb_t, sx(int'(b_out), B_OW), eb_d);
    v_tag    = "R2";
    in_valid = v;
    in_mode  = mode[1:0];
    a_in     = code[A_W-1:0];
    b_in     = code[B_W-1:0];
    if (v) begin
      ea_d = ref_round(sx(code % (1 << A_W), A_W), A_F, A_OW, mode, ta);
      eb_d = ref_round(sx(code % (1 << B_W), B_W), B_F, B_OW, mode, tb);
      ea_t = ta; eb_t = tb;
    end else begin
      ea_t = "R9"; eb_t = "R9";
    end
    ea_v = v; eb_v = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; in_mode = 2'b01;
    a_in = '1; b_in = '1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen before any post-reset edge
    ea_v = 0; eb_v = 0; ea_d = 0; eb_d = 0;
    ea_t = "R1"; eb_t = "R1"; v_tag = "R1";
    in_valid = 1'b0;
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < (1 << A_W); c++) begin
        step(1'b1, c, m);
        if (c % 7 == 3) step(1'b0, (c * 37 + 5) % (1 << A_W), (m + 1) % 4);
      end
    end
    step(1'b0, 0, 0);
    step(1'b0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule